// File: doc/BRIEF.md
# Edge-Interrupt 16-bit GPIO Controller

This block gives a processor sixteen general-purpose I/O lines behind a small register interface. Each line is either an input or an output. Output lines drive a value held in a data register. Input lines are synchronized and watched for a transition. Each input line chooses whether that transition is a rising or a falling edge. A line that is unmasked and sees its chosen edge latches a status bit. A single interrupt output stays high while any status bit is set.

Software sets the direction, edge choice and mask for each line. It can read the synchronized pin levels through a per-line read-enable mask, and it clears latched events by writing ones to the status register.

Every bus access is classified by a combinational decoder into one of four kinds: none, read, write or rejected. The decoder uses a `unique case` that names each kind. Only halfword (16-bit) accesses reach the registers.

Top module: `gpio16_edge_irq`

## Requirements
- R1: After reset, every line is an input (direction all ones), every line is masked (mask all ones), status is 0x0000, data-output is 0x0000, the read-enable mask is 0xFFFF, `irq_o` is low and `pin_out` is 0x0000.
- R2: Registers sit at byte offsets 0x04 data-output, 0x08 direction, 0x0C edge select, 0x10 interrupt mask and 0x18 read-enable mask. All of them read back the full 16 bits written. A write to offset 0x00 changes nothing. A read of an unmapped offset returns 0x0000.
- R3: A read of offset 0x00 returns the synchronized input levels ANDed with the read-enable mask.
- R4: `pin_out` equals data-output ANDed with the inverse of direction (direction bit 1 = input, 0 = output). The new value appears on the clock edge that commits a write to either register.
- R5: Edge-select bit 1 means a 0-to-1 transition is an event, and bit 0 means a 1-to-0 transition is an event. The opposite transition sets nothing. An event sets its status bit (offset 0x14) by the third rising clock edge after the pin changes.
- R6: A transition on a line whose direction bit is 0 or whose mask bit is 1 sets no status bit. Clearing the mask later does not bring back an event that was missed.
- R7: A write to offset 0x14 clears exactly those status bits whose write-data bit is 1. Every other status bit stays set.
- R8: `irq_o` is high exactly when at least one status bit is set, and it drops once all of them are cleared.
- R9: Only accesses with `bus_size` = 1 (halfword) are accepted. Size codes 0 (byte), 2 (word) and 3 change no register, and a rejected read returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access width code: 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read request |
| pin_in | input | 16 | Asynchronous input pins |
| pin_out | output | 16 | Driven output pins |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
Two things are hard to reach from the ports. One is an event that arrives while some status bits are already set and others are being cleared. The other is proving that a masked or output-configured line really latched nothing.

The stimulus walks a table of edge-select settings and before/after pin patterns. Each pattern mixes rising, falling and wrong-direction transitions across lines. Before each transition the bench clears status, so every expected status word is exact.

Directed sequences then cover the remaining cases:
- They set two status bits and clear them one at a time, so the interrupt is observed held and then dropped.
- They toggle masked lines and output lines, then unmask and read status again to show no event was kept.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
    localparam int OFF_W = 8;
    localparam logic [OFF_W-1:0] OFF_DIN    = 8'h00;
    localparam logic [OFF_W-1:0] OFF_DOUT   = 8'h04;
    localparam logic [OFF_W-1:0] OFF_DIR    = 8'h08;
    localparam logic [OFF_W-1:0] OFF_EDGE   = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_MASK   = 8'h10;
    localparam logic [OFF_W-1:0] OFF_STAT   = 8'h14;
    localparam logic [OFF_W-1:0] OFF_RDMASK = 8'h18;

    localparam logic [1:0] SIZE_HALF = 2'd1;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_READ   = 2'd1,
        ACC_WRITE  = 2'd2,
        ACC_REJECT = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] is_input_i,
    input  logic [WIDTH-1:0] masked_i,
    input  logic [WIDTH-1:0] rise_sel_i,
    output logic [WIDTH-1:0] hit_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            logic went_up, went_down, wanted;
            always_comb begin
                went_up   = level_i[i] & ~prev_q[i];
                went_down = ~level_i[i] & prev_q[i];
                wanted    = rise_sel_i[i] ? went_up : went_down;
                hit_o[i]  = wanted & is_input_i[i] & ~masked_i[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  level_i,
    input  logic [WIDTH-1:0]  hit_i,
    output logic [WIDTH-1:0]  rdata_o,
    output logic [WIDTH-1:0]  dout_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  rise_o,
    output logic [WIDTH-1:0]  mask_o,
    output logic [WIDTH-1:0]  status_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    acc_kind_t        acc;
    logic [WIDTH-1:0] dout_q, dir_q, rise_q, mask_q, rdmask_q, status_q;
    logic [WIDTH-1:0] status_d, read_mux, rdata_q;
    logic             wr_stat;

    always_comb begin
        if (!req_i)                   acc = ACC_NONE;
        else if (size_i != SIZE_HALF) acc = ACC_REJECT;
        else if (we_i)                acc = ACC_WRITE;
        else                          acc = ACC_READ;
    end

    assign wr_stat = (acc == ACC_WRITE) && (addr_i == ADDR_W'(OFF_STAT));

    always_comb begin
        status_d = status_q;
        if (wr_stat) status_d = status_q & ~wdata_i;
        status_d = status_d | hit_i;
    end

    always_comb begin
        read_mux = '0;
        case (addr_i)
            ADDR_W'(OFF_DIN):    read_mux = level_i & rdmask_q;
            ADDR_W'(OFF_DOUT):   read_mux = dout_q;
            ADDR_W'(OFF_DIR):    read_mux = dir_q;
            ADDR_W'(OFF_EDGE):   read_mux = rise_q;
            ADDR_W'(OFF_MASK):   read_mux = mask_q;
            ADDR_W'(OFF_STAT):   read_mux = status_q;
            ADDR_W'(OFF_RDMASK): read_mux = rdmask_q;
            default:             read_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= ALL_ONES;
            rise_q   <= '0;
            mask_q   <= ALL_ONES;
            rdmask_q <= ALL_ONES;
            status_q <= '0;
            rdata_q  <= '0;
        end else begin
            status_q <= status_d;
            unique case (acc)
                ACC_NONE: ;
                ACC_READ:   rdata_q <= read_mux;
                ACC_REJECT: rdata_q <= '0;
                ACC_WRITE: begin
                    case (addr_i)
                        ADDR_W'(OFF_DOUT):   dout_q   <= wdata_i;
                        ADDR_W'(OFF_DIR):    dir_q    <= wdata_i;
                        ADDR_W'(OFF_EDGE):   rise_q   <= wdata_i;
                        ADDR_W'(OFF_MASK):   mask_q   <= wdata_i;
                        ADDR_W'(OFF_RDMASK): rdmask_q <= wdata_i;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    assign rdata_o  = rdata_q;
    assign dout_o   = dout_q;
    assign dir_o    = dir_q;
    assign rise_o   = rise_q;
    assign mask_o   = mask_q;
    assign status_o = status_q;

    // R6
    status_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q)) & ~($past(dir_q) & ~$past(mask_q))) == '0);

    // R9
    reject_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i != SIZE_HALF) |=> ($stable(dout_q) && $stable(dir_q)
            && $stable(rise_q) && $stable(mask_q) && $stable(rdmask_q)));

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && (&wdata_i) && hit_i == '0) |=> (status_q == '0));
endmodule

// File: rtl/gpio16_edge_irq.sv
module gpio16_edge_irq
    import gpio16_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic              irq_o
);
    logic [WIDTH-1:0] level, hit, dout, dir, rise, mask, status;

    gpio16_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(level)
    );

    gpio16_edge #(.WIDTH(WIDTH)) u_edge (
        .clk(clk), .rst_n(rst_n), .level_i(level), .is_input_i(dir),
        .masked_i(mask), .rise_sel_i(rise), .hit_o(hit)
    );

    gpio16_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req_i(bus_req), .we_i(bus_we),
        .addr_i(bus_addr), .size_i(bus_size), .wdata_i(bus_wdata),
        .level_i(level), .hit_i(hit), .rdata_o(bus_rdata),
        .dout_o(dout), .dir_o(dir), .rise_o(rise), .mask_o(mask),
        .status_o(status)
    );

    assign pin_out = dout & ~dir;
    assign irq_o   = |status;

    // R4
    out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_size == SIZE_HALF && bus_addr == ADDR_W'(OFF_DIR))
        |=> ((pin_out & $past(bus_wdata)) == '0));
endmodule

// File: tb/tb_gpio16_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio16_edge_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic [15:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out;
    logic        irq_o;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    gpio16_edge_irq dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .irq_o(irq_o)
    );

    // {edge select, pins before, pins after, expected status}
    localparam logic [63:0] VEC [6] = '{
        {16'hFFFF, 16'h0000, 16'h0001, 16'h0001},
        {16'h0000, 16'hFFFF, 16'hFFFE, 16'h0001},
        {16'hFFFF, 16'hFFFF, 16'hFFFE, 16'h0000},
        {16'h00FF, 16'h00F0, 16'hFF0F, 16'h000F},
        {16'h0F0F, 16'hAAAA, 16'h5555, 16'hA5A5},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_size = 2'd1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'd1);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        @(negedge clk);
        bus_req = 1'b0; bus_size = 2'd1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_out", pin_out, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0000);
        rd(8'h08, r); chk("R1 dir", r, 16'hFFFF);
        rd(8'h10, r); chk("R1 mask", r, 16'hFFFF);
        rd(8'h14, r); chk("R1 status", r, 16'h0000);
        rd(8'h04, r); chk("R1 dout", r, 16'h0000);
        rd(8'h18, r); chk("R1 rdmask", r, 16'hFFFF);

        // R5 table walk: all inputs, none masked
        wr(8'h10, 16'h0000);
        foreach (VEC[k]) begin
            wr(8'h0C, VEC[k][63:48]);
            pin_in = VEC[k][47:32];
            settle();
            wr(8'h14, 16'hFFFF);
            pin_in = VEC[k][31:16];
            settle();
            rd(8'h14, r); chk("R5 status vector", r, VEC[k][15:0]);
            chk("R8 irq vector", {15'd0, irq_o}, {15'd0, VEC[k][15:0] != 16'h0});
        end

        // R2 readback and unmapped offset
        wr(8'h0C, 16'h3C5A); rd(8'h0C, r); chk("R2 edge readback", r, 16'h3C5A);
        wr(8'h18, 16'h1234); rd(8'h18, r); chk("R2 rdmask readback", r, 16'h1234);
        rd(8'h1C, r); chk("R2 unmapped read", r, 16'h0000);

        // R3 data input masked by read-enable
        pin_in = 16'hA5A5; settle();
        wr(8'h18, 16'hFFFF); rd(8'h00, r); chk("R3 din full", r, 16'hA5A5);
        wr(8'h18, 16'h00FF); rd(8'h00, r); chk("R3 din masked", r, 16'h00A5);
        wr(8'h00, 16'h0000); rd(8'h00, r); chk("R2 din write ignored", r, 16'h00A5);
        wr(8'h18, 16'hFFFF);

        // R4 output gating
        wr(8'h04, 16'hF00F); chk("R4 all inputs drive 0", pin_out, 16'h0000);
        wr(8'h08, 16'h00FF); chk("R4 dir update", pin_out, 16'hF000);
        wr(8'h04, 16'hFFFF); chk("R4 dout update", pin_out, 16'hFF00);
        rd(8'h04, r); chk("R2 dout readback", r, 16'hFFFF);

        // R6 output lines and masked lines do not latch
        wr(8'h0C, 16'hFFFF); pin_in = 16'h0000; settle(); wr(8'h14, 16'hFFFF);
        wr(8'h10, 16'h000F);
        pin_in = 16'hFF0F; settle();
        rd(8'h14, r); chk("R6 output/masked ignored", r, 16'h0000);
        chk("R6 no irq", {15'd0, irq_o}, 16'h0000);
        wr(8'h10, 16'h0000); settle();
        rd(8'h14, r); chk("R6 unmask no replay", r, 16'h0000);

        // R7 / R8 partial clear
        wr(8'h08, 16'hFFFF); pin_in = 16'h0000; settle(); wr(8'h14, 16'hFFFF);
        pin_in = 16'h0009; settle();
        rd(8'h14, r); chk("R7 two set", r, 16'h0009);
        wr(8'h14, 16'h0001);
        rd(8'h14, r); chk("R7 partial clear", r, 16'h0008);
        chk("R8 irq held", {15'd0, irq_o}, 16'h0001);
        wr(8'h14, 16'h0008);
        chk("R8 irq dropped", {15'd0, irq_o}, 16'h0000);

        // R9 width rejection
        wr(8'h08, 16'h0000);
        wr(8'h04, 16'h1111, 2'd2);
        rd(8'h04, r); chk("R9 word write rejected", r, 16'hFFFF);
        wr(8'h04, 16'h2222, 2'd0);
        chk("R9 byte write rejected", pin_out, 16'hFFFF);
        rd(8'h04, r, 2'd0); chk("R9 byte read zero", r, 16'h0000);
        rd(8'h04, r, 2'd3); chk("R9 reserved read zero", r, 16'h0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule